// File: doc/BRIEF.md
# ADC calibration sequencer

This controller steers one sigma-delta converter channel through its operating modes and runs its automatic calibrations. A 3-bit mode value is written through a strobe. Two of the values start conversions: one runs without end, the other runs a single conversion cycle. Four values start a calibration, which is offset or gain, and self (internal references) or system (external input). The controller drives the source selection for the converter input and counts the decimation filter's result strobes. It captures the filter samples it needs and works out a new coefficient. It then writes that coefficient into its own offset or gain register and reports it on a write port.

A calibration measures one conversion cycle of filter results per stage. Such a cycle is three filter periods with chopping off and two with chopping on. Offset calibration has one stage, so the new offset is the sample delivered on the last strobe. Gain calibration has two stages, zero scale and then full scale, so it takes twice as long. The span between the two captures feeds a 16-step serial restoring divider, which yields gain = 0x8000 × ideal span / measured span. Any calibration stops a running conversion at once and always ends in idle, with a one-clock completion pulse.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset the offset register holds OFS_DEF (0), the gain register holds GAIN_DEF (0x8000), mode_q is 000, and busy, done, conv_run, coef_we and cal_err are low. src_sel is 00.
- R2: Writing 001 sets conv_run and keeps it high across any number of filter strobes. Writing 010 keeps conv_run high until the Nth filter strobe, then clears it and sets mode_q to 000. N is 3 when chop_en is low and 2 when it is high.
- R3: Writing a mode with bit 2 set (100 self offset, 101 self gain, 110 system offset, 111 system gain) clears conv_run and raises busy on the next clock, even during a conversion. A filter strobe in the same cycle as that write does not count toward the calibration.
- R4: An offset calibration completes on its Nth counted strobe. A gain calibration needs 2N counted strobes: N at zero scale, then N at full scale.
- R5: src_sel encodes 00 external input, 01 internal zero, 10 internal full scale. Self offset uses 01. Self gain uses 01 and then 10. Both system calibrations use 00. Every other state uses 00.
- R6: An offset calibration loads the sample of its final strobe into the offset register. It pulses coef_we with coef_sel 0 and that sample on coef_data, in the same cycle as done.
- R7: A gain calibration with span S = full − zero (signed samples) where S > 0 loads floor(IDEAL_SPAN·32768/S) into the gain register, clamped to 0xFFFF. coef_sel is 1. When no clamp applies, done comes 17 clocks after the final strobe. When the clamp applies, done comes in the strobe's own clock.
- R8: A gain calibration with S ≤ 0 leaves the gain register unchanged, gives no coef_we, and sets cal_err together with done. The next calibration start clears cal_err.
- R9: Every calibration ends with done high for exactly one clock, with busy low and mode_q 000 in that same clock.
- R10: A mode write while busy is ignored, and the calibration runs on unchanged.
- R11: The reserved value 011 is treated as idle: mode_q reads 000 and conv_run stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode value to write |
| chop_en | input | 1 | Chopping enabled (sets periods per conversion cycle) |
| flt_done | input | 1 | Filter result strobe |
| flt_sample | input | DW | Filter result, two's complement |
| conv_run | output | 1 | Converter running a conversion |
| src_sel | output | 2 | Input source select |
| coef_we | output | 1 | Coefficient write pulse |
| coef_sel | output | 1 | 0 offset, 1 gain |
| coef_data | output | DW | Coefficient being written |
| offset_coef | output | DW | Offset register |
| gain_coef | output | DW | Gain register |
| mode_q | output | 3 | Current mode |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished (one clock) |
| cal_err | output | 1 | Last gain calibration had a non-positive span |

## Verification
Two collisions matter. The first is a calibration write landing in the same cycle as a filter strobe. The second is the same write landing on the strobe that would end a single conversion. The bench drives both signals in one cycle. It then requires conv_run to drop and busy to rise, and the calibration to need a full N further strobes. That shows the write won and the coincident strobe was not counted. Gain spans are swept across the clamp boundary and through zero and negative values, and each result is compared with a quotient computed in the bench.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    MD_IDLE   = 3'b000,
    MD_CONT   = 3'b001,
    MD_SINGLE = 3'b010,
    MD_RSV    = 3'b011,
    MD_SOFS   = 3'b100,
    MD_SGAIN  = 3'b101,
    MD_XOFS   = 3'b110,
    MD_XGAIN  = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_FULL = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONT,
    ST_SINGLE,
    ST_OFS,
    ST_GZ,
    ST_GF,
    ST_DIV
  } state_e;

endpackage

// File: rtl/adc_cal_percnt.sv
module adc_cal_percnt #(
  parameter int N_OFF = 3,
  parameter int N_ON  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic chop,
  output logic hit
);
  localparam int NMAX = (N_OFF > N_ON) ? N_OFF : N_ON;
  localparam int CW   = (NMAX > 2) ? $clog2(NMAX) : 1;
  localparam logic [CW-1:0] LAST_OFF = CW'(N_OFF - 1);
  localparam logic [CW-1:0] LAST_ON  = CW'(N_ON - 1);
  localparam logic [CW-1:0] LAST_MAX = CW'(NMAX - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = chop ? LAST_ON : LAST_OFF;
  assign hit  = tick && !clr && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || hit)     cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_MAX);

endmodule

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-2:0] num_hi,
  input  logic [DW-1:0] num_lo,
  input  logic [DW-1:0] divisor,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int SW = $clog2(DW);
  localparam logic [SW-1:0] LAST = SW'(DW - 1);

  logic          run;
  logic [SW-1:0] cnt;
  logic [DW-1:0] rem;
  logic [DW-1:0] dvs;
  logic [DW:0]   rem_sh;
  logic          ge;

  function automatic logic [DW:0] shift_in(input logic [DW-1:0] r, input logic b);
    return {r, b};
  endfunction

  assign rem_sh = shift_in(rem, quo[DW-1]);
  assign ge     = rem_sh >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      rem <= '0;
      dvs <= '0;
      quo <= '0;
      fin <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
      rem <= {1'b0, num_hi};
      dvs <= divisor;
      quo <= num_lo;
      fin <= 1'b0;
    end else if (run) begin
      rem <= ge ? DW'(rem_sh - {1'b0, dvs}) : rem_sh[DW-1:0];
      quo <= {quo[DW-2:0], ge};
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  // R7
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> rem < dvs);

  // R7
  div_fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef #(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] OFS_DEF  = '0,
  parameter logic [DW-1:0] GAIN_DEF = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ofs_q,
  output logic [DW-1:0] gain_q
);
  logic [DW-1:0] regs [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam logic [DW-1:0] DEF = (g == 0) ? OFS_DEF : GAIN_DEF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       regs[g] <= DEF;
      else if (we && (sel == g[0]))     regs[g] <= wdata;
    end
  end

  assign ofs_q  = regs[0];
  assign gain_q = regs[1];

  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel) |=> $stable(gain_q));

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int            DW         = 16,
  parameter int            N_OFF      = 3,
  parameter int            N_ON       = 2,
  parameter logic [DW-1:0] IDEAL_SPAN = 16'h6000,
  parameter logic [DW-1:0] OFS_DEF    = '0,
  parameter logic [DW-1:0] GAIN_DEF   = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [2:0]    mode_in,
  input  logic          chop_en,
  input  logic          flt_done,
  input  logic [DW-1:0] flt_sample,
  output logic          conv_run,
  output logic [1:0]    src_sel,
  output logic          coef_we,
  output logic          coef_sel,
  output logic [DW-1:0] coef_data,
  output logic [DW-1:0] offset_coef,
  output logic [DW-1:0] gain_coef,
  output logic [2:0]    mode_q,
  output logic          busy,
  output logic          done,
  output logic          cal_err
);
  localparam logic [DW-1:0] GAIN_MAX = '1;

  state_e        st;
  mode_e         mode_r;
  logic [DW-1:0] z_cap;

  // named internal events
  logic          accept;
  logic          tick;
  logic          hit;
  logic          fin_now;
  logic          wr_en;
  logic          wr_sel;
  logic [DW-1:0] wr_dat;
  logic          span_bad;
  logic          span_clamp;
  logic          div_start;
  logic          div_fin;
  logic [DW-1:0] div_quo;
  logic signed [DW:0] span_w;

  function automatic logic signed [DW:0] span_of(input logic [DW-1:0] hi_s,
                                                 input logic [DW-1:0] lo_s);
    return $signed({hi_s[DW-1], hi_s}) - $signed({lo_s[DW-1], lo_s});
  endfunction

  function automatic logic clamps(input logic signed [DW:0] s);
    return {s[DW-1:0], 1'b0} <= {1'b0, IDEAL_SPAN};
  endfunction

  function automatic state_e entry_state(input logic [2:0] m);
    case (m)
      MD_CONT:          return ST_CONT;
      MD_SINGLE:        return ST_SINGLE;
      MD_SOFS, MD_XOFS: return ST_OFS;
      MD_SGAIN, MD_XGAIN: return ST_GZ;
      default:          return ST_IDLE;
    endcase
  endfunction

  assign busy     = (st == ST_OFS) || (st == ST_GZ) || (st == ST_GF) || (st == ST_DIV);
  assign conv_run = (st == ST_CONT) || (st == ST_SINGLE);
  assign mode_q   = mode_r;
  assign accept   = mode_wr && !busy;
  assign tick     = flt_done && ((st == ST_SINGLE) || (st == ST_OFS) ||
                                 (st == ST_GZ) || (st == ST_GF));

  assign span_w     = span_of(flt_sample, z_cap);
  assign span_bad   = span_w[DW] || (span_w == '0);
  assign span_clamp = clamps(span_w);

  adc_cal_percnt #(.N_OFF(N_OFF), .N_ON(N_ON)) u_percnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .tick  (tick),
    .chop  (chop_en),
    .hit   (hit)
  );

  assign div_start = (st == ST_GF) && hit && !span_bad && !span_clamp;

  adc_cal_div #(.DW(DW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .num_hi  (IDEAL_SPAN[DW-1:1]),
    .num_lo  ({IDEAL_SPAN[0], {(DW-1){1'b0}}}),
    .divisor (span_w[DW-1:0]),
    .fin     (div_fin),
    .quo     (div_quo)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    wr_dat  = flt_sample;
    fin_now = 1'b0;
    case (st)
      ST_OFS: if (hit) begin
        wr_en   = 1'b1;
        fin_now = 1'b1;
      end
      ST_GF: if (hit) begin
        if (span_bad) begin
          fin_now = 1'b1;
        end else if (span_clamp) begin
          wr_en   = 1'b1;
          wr_sel  = 1'b1;
          wr_dat  = GAIN_MAX;
          fin_now = 1'b1;
        end
      end
      ST_DIV: if (div_fin) begin
        wr_en   = 1'b1;
        wr_sel  = 1'b1;
        wr_dat  = div_quo;
        fin_now = 1'b1;
      end
      default: ;
    endcase
  end

  adc_cal_coef #(.DW(DW), .OFS_DEF(OFS_DEF), .GAIN_DEF(GAIN_DEF)) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en),
    .sel    (wr_sel),
    .wdata  (wr_dat),
    .ofs_q  (offset_coef),
    .gain_q (gain_coef)
  );

  always_comb begin
    case (st)
      ST_OFS:  src_sel = (mode_r == MD_SOFS)  ? SRC_ZERO : SRC_EXT;
      ST_GZ:   src_sel = (mode_r == MD_SGAIN) ? SRC_ZERO : SRC_EXT;
      ST_GF:   src_sel = (mode_r == MD_SGAIN) ? SRC_FULL : SRC_EXT;
      default: src_sel = SRC_EXT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mode_r    <= MD_IDLE;
      z_cap     <= '0;
      done      <= 1'b0;
      cal_err   <= 1'b0;
      coef_we   <= 1'b0;
      coef_sel  <= 1'b0;
      coef_data <= '0;
    end else begin
      done      <= fin_now;
      coef_we   <= wr_en;
      coef_sel  <= wr_sel;
      coef_data <= wr_en ? wr_dat : coef_data;
      if (accept) begin
        st     <= entry_state(mode_in);
        mode_r <= (mode_in == MD_RSV) ? MD_IDLE : mode_e'(mode_in);
        if (mode_in[2]) cal_err <= 1'b0;
      end else if (fin_now) begin
        st     <= ST_IDLE;
        mode_r <= MD_IDLE;
        if (st == ST_GF && span_bad) cal_err <= 1'b1;
      end else begin
        case (st)
          ST_SINGLE: if (hit) begin
            st     <= ST_IDLE;
            mode_r <= MD_IDLE;
          end
          ST_GZ: if (hit) begin
            z_cap <= flt_sample;
            st    <= ST_GF;
          end
          ST_GF: if (div_start) st <= ST_DIV;
          default: ;
        endcase
      end
    end
  end

  // R9
  idle_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (mode_q == 3'b000));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !busy && mode_in[2]) |=> busy && !conv_run);

  // R10
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_wr && !fin_now) |=> (mode_q == $past(mode_q)));

  // R8
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_err) |-> done && !coef_we);

  // R6
  write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> done);

endmodule

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;
  localparam int DW = 16;
  localparam longint IDEAL = 64'h6000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [2:0]    mode_in = 3'b000;
  logic          chop_en = 1'b0;
  logic          flt_done = 1'b0;
  logic [DW-1:0] flt_sample = '0;
  logic          conv_run;
  logic [1:0]    src_sel;
  logic          coef_we;
  logic          coef_sel;
  logic [DW-1:0] coef_data;
  logic [DW-1:0] offset_coef;
  logic [DW-1:0] gain_coef;
  logic [2:0]    mode_q;
  logic          busy;
  logic          done;
  logic          cal_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  adc_cal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .chop_en(chop_en), .flt_done(flt_done), .flt_sample(flt_sample),
    .conv_run(conv_run), .src_sel(src_sel), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_data(coef_data), .offset_coef(offset_coef),
    .gain_coef(gain_coef), .mode_q(mode_q), .busy(busy), .done(done),
    .cal_err(cal_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      summary();
    end
  end

  task automatic wr_mode(input logic [2:0] m);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic pulse(input logic [DW-1:0] s);
    flt_done = 1'b1; flt_sample = s;
    @(negedge clk);
    flt_done = 1'b0;
  endtask

  task automatic wr_and_pulse(input logic [2:0] m, input logic [DW-1:0] s);
    mode_wr = 1'b1; mode_in = m; flt_done = 1'b1; flt_sample = s;
    @(negedge clk);
    mode_wr = 1'b0; flt_done = 1'b0;
  endtask

  function automatic int nper(input logic c);
    return c ? 2 : 3;
  endfunction

  function automatic longint exp_gain(input longint span);
    longint q;
    q = (IDEAL * 32768) / span;
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic run_offset(input logic [2:0] m, input logic [DW-1:0] s);
    int n;
    n = nper(chop_en);
    wr_mode(m);
    chk("R3 busy", busy, 1);
    chk("R5 src", src_sel, (m == 3'b100) ? 1 : 0);
    for (int i = 0; i < n - 1; i++) pulse(DW'(16'h1111 * (i + 3)));
    chk("R4 busy before last", busy, 1);
    chk("R4 no done early", done, 0);
    pulse(s);
    chk("R9 done", done, 1);
    chk("R9 busy low", busy, 0);
    chk("R9 mode idle", mode_q, 0);
    chk("R6 offset reg", offset_coef, s);
    chk("R6 we", coef_we, 1);
    chk("R6 sel", coef_sel, 0);
    chk("R6 data", coef_data, s);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic run_gain(input logic [2:0] m, input logic [DW-1:0] z,
                          input logic [DW-1:0] f);
    int n;
    longint span;
    longint prev;
    int k;
    n = nper(chop_en);
    prev = longint'(gain_coef);
    span = longint'($signed(f)) - longint'($signed(z));
    wr_mode(m);
    chk("R8 err cleared at start", cal_err, 0);
    chk("R5 src zero stage", src_sel, (m == 3'b101) ? 1 : 0);
    for (int i = 0; i < n - 1; i++) pulse(DW'(16'h0707 * (i + 1)));
    pulse(z);
    chk("R4 still busy after stage 1", busy, 1);
    chk("R5 src full stage", src_sel, (m == 3'b101) ? 2 : 0);
    for (int i = 0; i < n - 1; i++) pulse(DW'(16'h2323 * (i + 1)));
    chk("R4 no done before 2N", done, 0);
    pulse(f);
    if (span <= 0) begin
      chk("R8 done", done, 1);
      chk("R8 err", cal_err, 1);
      chk("R8 no write", coef_we, 0);
      chk("R8 gain kept", gain_coef, prev);
    end else if (exp_gain(span) == 65535) begin
      chk("R7 clamp done", done, 1);
      chk("R7 clamp gain", gain_coef, 65535);
      chk("R7 sel", coef_sel, 1);
    end else begin
      chk("R7 busy dividing", busy, 1);
      k = 0;
      while (!done && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk("R7 latency", k, 17);
      chk("R7 gain", gain_coef, exp_gain(span));
      chk("R7 data", coef_data, exp_gain(span));
      chk("R7 we", coef_we, 1);
      chk("R9 mode idle", mode_q, 0);
    end
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  initial begin
    logic [DW-1:0] zs [8];
    logic [DW-1:0] fs [8];
    logic [DW-1:0] os [4];
    zs = '{16'h0000, 16'h0100, 16'hF000, 16'h0000, 16'h1000, 16'h1000, 16'h2000, 16'h8000};
    fs = '{16'h6000, 16'h5100, 16'h5000, 16'h3000, 16'h4001, 16'h1000, 16'h1000, 16'h7FFF};
    os = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFF3C};
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 offset", offset_coef, 0);
    chk("R1 gain", gain_coef, 16'h8000);
    chk("R1 mode", mode_q, 0);
    chk("R1 busy", busy, 0);
    chk("R1 conv_run", conv_run, 0);
    chk("R1 src", src_sel, 0);
    chk("R1 done", done, 0);
    chk("R1 err", cal_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reserved
    wr_mode(3'b011);
    chk("R11 mode", mode_q, 0);
    chk("R11 conv_run", conv_run, 0);

    // R2 continuous
    wr_mode(3'b001);
    chk("R2 cont run", conv_run, 1);
    for (int i = 0; i < 5; i++) pulse(16'h0042);
    chk("R2 cont still", conv_run, 1);
    chk("R2 cont mode", mode_q, 1);
    wr_mode(3'b000);
    chk("R2 stop", conv_run, 0);

    for (int c = 0; c < 2; c++) begin
      chop_en = c[0];
      // R2 single
      wr_mode(3'b010);
      for (int i = 0; i < nper(chop_en) - 1; i++) pulse(16'h0010);
      chk("R2 single running", conv_run, 1);
      pulse(16'h0010);
      chk("R2 single end", conv_run, 0);
      chk("R2 single mode", mode_q, 0);
      // R6 offset sweep
      for (int j = 0; j < 4; j++) begin
        run_offset(3'b100, os[j]);
        run_offset(3'b110, ~os[j]);
      end
      // R7 R8 gain sweep
      for (int j = 0; j < 8; j++) begin
        run_gain(3'b101, zs[j], fs[j]);
        run_gain(3'b111, fs[j], zs[j]);
      end
      // R3 abort of continuous with coincident strobe
      wr_mode(3'b001);
      wr_and_pulse(3'b100, 16'h5555);
      chk("R3 conv dropped", conv_run, 0);
      chk("R3 busy", busy, 1);
      for (int i = 0; i < nper(chop_en) - 1; i++) pulse(16'h0001);
      chk("R3 strobe not counted", done, 0);
      // R10 write during busy
      wr_mode(3'b001);
      chk("R10 mode kept", mode_q, 4);
      chk("R10 no conv", conv_run, 0);
      pulse(16'h0ABC);
      chk("R3 done after N", done, 1);
      chk("R3 offset", offset_coef, 16'h0ABC);
      // R3 coincident with last single strobe
      wr_mode(3'b010);
      for (int i = 0; i < nper(chop_en) - 1; i++) pulse(16'h0002);
      wr_and_pulse(3'b110, 16'h0003);
      chk("R3 cal wins", mode_q, 6);
      chk("R3 busy single", busy, 1);
      for (int i = 0; i < nper(chop_en) - 1; i++) pulse(16'h0004);
      chk("R3 not early", busy, 1);
      pulse(16'h0BEE);
      chk("R3 finish", offset_coef, 16'h0BEE);
      @(negedge clk);
    end
    summary();
  end
endmodule